// File: doc/BRIEF.md
# Split-Transaction Read Controller

This block sits on the memory side of a bus that splits each read into two separate transfers. A master places a read request, made of an address and a requester tag, on the request port. The request takes exactly one bus cycle, and the bus is free again in the next cycle. The controller holds accepted requests in a queue. It issues them to a memory whose read latency is fixed at `MEM_LAT` cycles and follows every read through that latency with a matching pipeline of tags. Finished reads are stored in a return buffer. While the buffer holds a reply, the controller asks for bus mastership. It drives a reply only in a cycle where its grant is present, and the reply carries the requester's tag unchanged.

The number of reads that can be in flight is sized from the memory latency `MEM_LAT` and the bus cycle `BUS_CYC`, both in clock cycles: `INFLIGHT = ceil(MEM_LAT / BUS_CYC)`. The request queue holds `max(2, INFLIGHT)` entries. The return buffer holds `INFLIGHT + 1` entries, and the controller never has more memory reads outstanding than that, counting both the reads inside the latency pipeline and the replies in the buffer.

Request port back-pressure: a request transfers in a cycle where `req_valid` and `req_ready` are both high. When the queue is full, `req_ready` is low and `req_retry` marks the offered request as refused. The master must offer it again later, and the controller keeps no record of it. Reply port: `bus_gnt` acts as the ready signal. `rsp_valid`, `rsp_data` and `rsp_tag` are meaningful only in a cycle where `rsp_valid` is high, and a reply completes in that same cycle.

Top module: `sptx_rd_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_req`, `rsp_valid` and `mem_rd_en` are all 0.
- R2: Every accepted request is issued to memory exactly once, as a cycle with `mem_rd_en` high and `mem_rd_addr` equal to its address. Issues happen in acceptance order, and none happens in the cycle the request is accepted.
- R3: If `req_valid` is high while `req_ready` is low, `req_retry` is high and the request is not accepted: no reply is ever produced for it. `req_retry` is low whenever a request is accepted.
- R4: A reply carries the word that memory returned for its address exactly `MEM_LAT` cycles after the issue cycle, together with the request's tag unchanged.
- R5: Replies leave in the order in which their requests were accepted. No reply is lost and no reply is duplicated.
- R6: `bus_req` is high whenever a reply is waiting. Once raised, it stays high until a cycle in which `bus_gnt` is high.
- R7: `rsp_valid` is high only in cycles where both `bus_req` and `bus_gnt` are high.
- R8: The number of memory reads issued but not yet replied never exceeds `INFLIGHT + 1`, which is 5 with the defaults.
- R9: With `bus_gnt` held low, the controller accepts exactly `max(2, INFLIGHT) + INFLIGHT + 1` requests and then refuses further requests. With the defaults this is 9.
- R10: When the controller is idle and `bus_gnt` is held high, a single request's reply appears `MEM_LAT + 2` cycles after the cycle in which the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request queue can take a request |
| req_retry | output | 1 | Offered request refused; retry later |
| req_addr | input | ADDR_W | Read address |
| req_tag | input | TAG_W | Requester tag |
| mem_rd_en | output | 1 | Memory read issue strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Memory data, MEM_LAT cycles after issue |
| bus_req | output | 1 | Request for bus mastership to return a reply |
| bus_gnt | input | 1 | Bus grant; acts as reply ready |
| rsp_valid | output | 1 | Reply driven this cycle |
| rsp_data | output | DATA_W | Reply data |
| rsp_tag | output | TAG_W | Tag of the original requester |

## Verification
The embedded assertions check the following on every cycle: the bus request is held until the grant arrives, the outstanding-read count and the queue occupancies stay within their bounds, and the return buffer never overflows. The reset state is also checked by assertion. Other properties need a reference model of expected traffic, so only the bench scenarios can show them. These are: the match of reply data and tag to each request, the preserved ordering, the exact capacity before retry starts, the refused request never reappearing, and the exact idle reply latency.

// File: rtl/sptx_pkg.sv
package sptx_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/sptx_fifo.sv
module sptx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = store[rptr];

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: a push into a full buffer only happens if a pop frees a slot
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |-> pop);
  // R9: occupancy never exceeds the configured depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5: nothing is taken from an empty buffer
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sptx_lat_pipe.sv
module sptx_lat_pipe #(
  parameter int STAGES = 4,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic [STAGES-1:0] v;
  logic [W-1:0]      d [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) v[0] <= 1'b0;
    else        v[0] <= in_v;
  end
  always_ff @(posedge clk) d[0] <= in_d;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) v[g] <= 1'b0;
      else        v[g] <= v[g-1];
    end
    always_ff @(posedge clk) d[g] <= d[g-1];
  end

  assign out_v = v[STAGES-1];
  assign out_d = d[STAGES-1];
endmodule

// File: rtl/sptx_rd_ctrl.sv
module sptx_rd_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 3,
  parameter int MEM_LAT = 4,
  parameter int BUS_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              req_retry,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag
);
  localparam int INFLIGHT = sptx_pkg::ceil_div(MEM_LAT, BUS_CYC);
  localparam int RQ_DEPTH = (INFLIGHT < 2) ? 2 : INFLIGHT;
  localparam int RB_DEPTH = INFLIGHT + 1;
  localparam int CNT_W    = $clog2(RB_DEPTH + 1);
  localparam int RQ_W     = ADDR_W + TAG_W;
  localparam int RB_W     = TAG_W + DATA_W;

  logic             rq_full, rq_empty, rq_push, issue;
  logic [RQ_W-1:0]  rq_head;
  logic             rb_full, rb_empty, rsp_fire;
  logic [RB_W-1:0]  rb_head;
  logic             lat_v;
  logic [TAG_W-1:0] lat_tag;
  logic [CNT_W-1:0] outstanding;

  // request side
  assign req_ready = !rq_full;
  assign req_retry = req_valid && rq_full;
  assign rq_push   = req_valid && !rq_full;

  sptx_fifo #(.W(RQ_W), .DEPTH(RQ_DEPTH)) i_req_q (
    .clk(clk), .rst_n(rst_n),
    .push(rq_push), .push_data({req_tag, req_addr}),
    .pop(issue), .head(rq_head), .empty(rq_empty), .full(rq_full)
  );

  // issue only while the return buffer has room for the result
  assign issue       = !rq_empty &&
                       (int'(outstanding) < RB_DEPTH + int'(rsp_fire));
  assign mem_rd_en   = issue;
  assign mem_rd_addr = rq_head[ADDR_W-1:0];

  sptx_lat_pipe #(.STAGES(MEM_LAT), .W(TAG_W)) i_lat (
    .clk(clk), .rst_n(rst_n),
    .in_v(issue), .in_d(rq_head[RQ_W-1:ADDR_W]),
    .out_v(lat_v), .out_d(lat_tag)
  );

  sptx_fifo #(.W(RB_W), .DEPTH(RB_DEPTH)) i_ret_q (
    .clk(clk), .rst_n(rst_n),
    .push(lat_v), .push_data({lat_tag, mem_rd_data}),
    .pop(rsp_fire), .head(rb_head), .empty(rb_empty), .full(rb_full)
  );

  // reply side: master request, drive only under grant
  assign bus_req   = !rb_empty;
  assign rsp_fire  = bus_req && bus_gnt;
  assign rsp_valid = rsp_fire;
  assign rsp_data  = rb_head[DATA_W-1:0];
  assign rsp_tag   = rb_head[RB_W-1:DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= '0;
    else begin
      case ({issue, rsp_fire})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: outstanding <= outstanding;
      endcase
    end
  end

  // R1: quiet outputs in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_req && !mem_rd_en && req_ready);
  // R6: bus request held until granted
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);
  // R8: outstanding reads bounded by the return buffer size
  a_r8_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outstanding) <= RB_DEPTH);
  // R8: data leaving the latency pipe always finds a slot
  a_r8_capture_room: assert property (@(posedge clk) disable iff (!rst_n)
    lat_v |-> !rb_full || rsp_fire);
endmodule

// File: tb/test_sptx_rd_ctrl.sv
module test_sptx_rd_ctrl;
  localparam int ADDR_W = 8, DATA_W = 16, TAG_W = 3, MEM_LAT = 4;
  localparam int INFLIGHT = 4;          // ceil(4/1)
  localparam int CAP = 4 + INFLIGHT + 1; // queue + return buffer

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_retry;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [DATA_W-1:0] mem_rd_data;
  logic bus_req, bus_gnt = 0, rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [TAG_W-1:0]  rsp_tag;

  always #5 clk = ~clk;

  sptx_rd_ctrl i_sptx_rd_ctrl (.*);

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  // memory model with fixed latency
  logic [DATA_W-1:0] mpipe [MEM_LAT];
  always @(posedge clk) begin
    mpipe[0] <= mem_rd_en ? mem_word(mem_rd_addr) : 16'hDEAD;
    for (int i = 1; i < MEM_LAT; i++) mpipe[i] <= mpipe[i-1];
  end
  assign mem_rd_data = mpipe[MEM_LAT-1];

  int tests = 0, fails = 0;
  logic [ADDR_W-1:0] exp_addr [1024];
  logic [TAG_W-1:0]  exp_tag  [1024];
  int wr_idx = 0, rd_idx = 0, iss_idx = 0, outst = 0, accepts = 0;
  logic prev_breq = 0, prev_gnt = 0;
  logic mon_on = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor, sampling away from the rising edge
  always begin
    @(negedge clk); #3;
    if (mon_on) begin
      if (mem_rd_en) begin
        check(iss_idx < wr_idx, "R2 issue without request", iss_idx, wr_idx);
        check(mem_rd_addr == exp_addr[iss_idx], "R2 issue address",
              mem_rd_addr, exp_addr[iss_idx]);
        iss_idx++; outst++;
      end
      if (rsp_valid) begin
        check(bus_gnt && bus_req, "R7 reply without grant", bus_gnt, 1);
        if (rd_idx < iss_idx) begin
          check(rsp_tag == exp_tag[rd_idx], "R4 reply tag", rsp_tag, exp_tag[rd_idx]);
          check(rsp_data == mem_word(exp_addr[rd_idx]), "R5 reply order/data",
                rsp_data, mem_word(exp_addr[rd_idx]));
        end else check(0, "R3 extra reply", rd_idx, iss_idx);
        rd_idx++; outst--;
      end
      check(outst <= INFLIGHT + 1, "R8 outstanding bound", outst, INFLIGHT + 1);
      if (prev_breq && !prev_gnt)
        check(bus_req, "R6 bus request dropped", bus_req, 1);
      if (req_valid && req_ready) begin
        check(!req_retry, "R3 retry on accept", req_retry, 0);
        exp_addr[wr_idx] = req_addr; exp_tag[wr_idx] = req_tag;
        wr_idx++; accepts++;
      end else if (req_valid)
        check(req_retry, "R3 retry when full", req_retry, 1);
      prev_breq = bus_req; prev_gnt = bus_gnt;
    end
  end

  task automatic drain();
    @(negedge clk); req_valid = 0; bus_gnt = 1;
    for (int i = 0; i < 100 && rd_idx != wr_idx; i++) @(negedge clk);
    repeat (MEM_LAT + 4) @(negedge clk);
    check(rd_idx == wr_idx, "R5 all replies returned", rd_idx, wr_idx);
    check(iss_idx == wr_idx, "R2 each issued once", iss_idx, wr_idx);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    check(req_ready == 1, "R1 req_ready", req_ready, 1);
    check(bus_req == 0, "R1 bus_req", bus_req, 0);
    check(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    check(mem_rd_en == 0, "R1 mem_rd_en", mem_rd_en, 0);
    mon_on = 1;

    // R10: idle latency with grant held
    @(negedge clk); bus_gnt = 1; req_valid = 1; req_addr = 8'h21; req_tag = 3'd5;
    begin
      int k = 0;
      @(negedge clk); req_valid = 0;
      k = 1;
      #4;
      while (!rsp_valid && k < 20) begin @(negedge clk); #4; k++; end
      check(k == MEM_LAT + 2, "R10 reply latency", k, MEM_LAT + 2);
    end
    drain();

    // R9: capacity with grant low, then R3 retry
    @(negedge clk); bus_gnt = 0; accepts = 0;
    for (int i = 0; i < 30; i++) begin
      req_valid = 1; req_addr = ADDR_W'(8'h40 + i); req_tag = TAG_W'(i);
      @(negedge clk);
    end
    check(accepts == CAP, "R9 accepted before retry", accepts, CAP);
    req_valid = 1; req_addr = 8'hEE; req_tag = 3'd7; #3;
    check(req_retry && !req_ready, "R3 refused when full", req_retry, 1);
    // R6: waiting reply holds bus request
    check(bus_req, "R6 request while waiting", bus_req, 1);
    drain();

    // random traffic
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      req_valid = ($urandom % 10) < 6;
      req_addr  = ADDR_W'($urandom);
      req_tag   = TAG_W'($urandom);
      bus_gnt   = ($urandom % 3) != 0;
    end
    drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule